// File: doc/BRIEF.md
# Modem Loopback and Mode Router

This block turns a set of static control pins, set by a host controller, into the modem's operating mode. The modes are tone dialing, low-speed, high-speed synchronous and high-speed asynchronous. Within those modes it applies any requested test loopback. It drives the receiver's band select, picks where transmit data and the transmit clock come from, isolates the terminal interface, and reports whether a remote loop is running.

Every control pin passes through a two-flop synchronizer on the system clock and is then decoded into a registered route state. The data and clock paths are plain multiplexers steered by that registered state.

Analog loopback inverts the receiver's originate/answer band so that the receiver hears the local transmitter. Local digital loop sends received data back into the transmitter. At high speed it also takes the transmit clock from the recovered receive clock. The remote-loop tone handshake is outside this block and appears only as an acknowledge input.

Top module: `modem_path_router`

## Requirements
- R1: Dialer mode (op_mode = 0) is selected exactly when test_sel, hs_phase1 and hs_phase2 are all 0. In dialer mode every loopback request is ignored: iso_out=0, rx_band_orig=orig_sel, tx_clk_out=int_tx_clk, rl_status=0.
- R2: Outside dialer mode, op_mode is 1 when speed_hi=0, 2 when speed_hi=1 and sync_sel=1, and 3 when speed_hi=1 and sync_sel=0.
- R3: Outside dialer mode, rx_band_orig equals orig_sel XOR aloop_req. Analog loopback is therefore honoured in all three data modes.
- R4: Local loop is active when lloop_req=1 outside dialer mode. While it is active, iso_out=1, term_rxd is forced to 1 (mark) and tx_data_out follows rx_data. Otherwise iso_out=0, term_rxd follows rx_data and tx_data_out follows term_txd.
- R5: tx_clk_out follows rx_rec_clk when local loop is active and op_mode is 2 or 3. Otherwise it follows int_tx_clk.
- R6: A remote loop is granted only when rloop_req=1, speed_hi=1, lloop_req=0 and the block is not in dialer mode. rl_status equals grant AND rloop_ack. A request made under any other condition leaves rl_status at 0.
- R7: A change on a control pin reaches the outputs on the third rising clock edge after it is applied, and not before.
- R8: While rst_n is low, op_mode=0, iso_out=0, rx_band_orig=0 and rl_status=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_sel | input | 1 | Test select pin |
| hs_phase1 | input | 1 | Handshake phase pin 1 |
| hs_phase2 | input | 1 | Handshake phase pin 2 |
| speed_hi | input | 1 | 1 selects high-speed operation |
| sync_sel | input | 1 | 1 selects synchronous operation at high speed |
| orig_sel | input | 1 | 1 selects the originate band |
| aloop_req | input | 1 | Analog loopback request |
| lloop_req | input | 1 | Local digital loop request |
| rloop_req | input | 1 | Remote digital loop request |
| rloop_ack | input | 1 | Far end acknowledged the remote loop |
| term_txd | input | 1 | Transmit data from the terminal |
| rx_data | input | 1 | Recovered receive data |
| int_tx_clk | input | 1 | Internally generated transmit clock |
| rx_rec_clk | input | 1 | Recovered receive clock |
| op_mode | output | 2 | Decoded operating mode |
| rx_band_orig | output | 1 | Receiver band select, 1 = originate band |
| iso_out | output | 1 | Terminal interface isolated |
| term_rxd | output | 1 | Receive data to the terminal |
| tx_data_out | output | 1 | Data into the transmitter |
| tx_clk_out | output | 1 | Clock for the transmitter |
| rl_status | output | 1 | Remote loop status |

## Verification
The embedded assertions check four things on every cycle: remote-loop status never appears outside high speed or alongside local loop, dialer mode keeps isolation and remote status off, and the receive-clock path is chosen only under a high-speed local loop. Only the bench's sweep can show the band inversion, the data and clock multiplexing for every combination of data levels, the exact mode code for each pin pattern, and the three-edge pin-to-output latency.

// File: rtl/modem_router_pkg.sv
package modem_router_pkg;

    localparam int NUM_PINS = 10;

    typedef enum logic [1:0] {
        MODE_DIAL     = 2'd0,
        MODE_LOW      = 2'd1,
        MODE_HS_SYNC  = 2'd2,
        MODE_HS_ASYNC = 2'd3
    } op_mode_e;

    typedef struct packed {
        logic test;
        logic hsk1;
        logic hsk2;
        logic high;
        logic sync;
        logic orig;
        logic aloop;
        logic lloop;
        logic rloop;
        logic rack;
    } pins_t;

    typedef struct packed {
        op_mode_e mode;
        logic     band_orig;
        logic     iso;
        logic     clk_from_rx;
        logic     rl_status;
    } route_t;

    localparam route_t ROUTE_RESET = '{mode: MODE_DIAL, band_orig: 1'b0, iso: 1'b0,
                                       clk_from_rx: 1'b0, rl_status: 1'b0};

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH  = 10,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[LAST];
endmodule

// File: rtl/mode_decode.sv
module mode_decode
    import modem_router_pkg::*;
(
    input  pins_t  pins,
    output route_t route
);
    logic dial;
    logic lloop_on;
    logic rl_grant;

    always_comb begin
        dial     = !(pins.test || pins.hsk1 || pins.hsk2);
        lloop_on = !dial && pins.lloop;
        rl_grant = !dial && pins.high && pins.rloop && !pins.lloop;

        route = ROUTE_RESET;
        if (dial) begin
            route.mode = MODE_DIAL;
        end else if (!pins.high) begin
            route.mode = MODE_LOW;
        end else if (pins.sync) begin
            route.mode = MODE_HS_SYNC;
        end else begin
            route.mode = MODE_HS_ASYNC;
        end
        route.band_orig   = pins.orig ^ (!dial && pins.aloop);
        route.iso         = lloop_on;
        route.clk_from_rx = lloop_on && pins.high;
        route.rl_status   = rl_grant && pins.rack;
    end
endmodule

// File: rtl/modem_path_router.sv
module modem_path_router
    import modem_router_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       test_sel,
    input  logic       hs_phase1,
    input  logic       hs_phase2,
    input  logic       speed_hi,
    input  logic       sync_sel,
    input  logic       orig_sel,
    input  logic       aloop_req,
    input  logic       lloop_req,
    input  logic       rloop_req,
    input  logic       rloop_ack,
    input  logic       term_txd,
    input  logic       rx_data,
    input  logic       int_tx_clk,
    input  logic       rx_rec_clk,
    output logic [1:0] op_mode,
    output logic       rx_band_orig,
    output logic       iso_out,
    output logic       term_rxd,
    output logic       tx_data_out,
    output logic       tx_clk_out,
    output logic       rl_status
);
    pins_t  pins_raw;
    pins_t  pins_sync;
    route_t route_d;
    route_t route_q;

    assign pins_raw = '{test: test_sel, hsk1: hs_phase1, hsk2: hs_phase2,
                        high: speed_hi, sync: sync_sel, orig: orig_sel,
                        aloop: aloop_req, lloop: lloop_req, rloop: rloop_req,
                        rack: rloop_ack};

    pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_pin_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_raw),
        .sync_out (pins_sync)
    );

    mode_decode i_mode_decode (
        .pins  (pins_sync),
        .route (route_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q <= ROUTE_RESET;
        end else begin
            route_q <= route_d;
        end
    end

    always_comb begin
        op_mode      = route_q.mode;
        rx_band_orig = route_q.band_orig;
        iso_out      = route_q.iso;
        rl_status    = route_q.rl_status;
        term_rxd     = route_q.iso ? 1'b1 : rx_data;
        tx_data_out  = route_q.iso ? rx_data : term_txd;
        tx_clk_out   = route_q.clk_from_rx ? rx_rec_clk : int_tx_clk;
    end

    // R6
    rl_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rl_status |-> op_mode[1]);

    // R6
    rl_lloop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rl_status |-> !iso_out);

    // R1
    dial_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == MODE_DIAL) |-> (!iso_out && !rl_status));

    // R5
    rx_clk_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_q.clk_from_rx |-> (iso_out && op_mode[1]));
endmodule

// File: tb/test_modem_path_router.sv
`timescale 1ns/1ps
module test_modem_path_router;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_sel = 0, hs_phase1 = 0, hs_phase2 = 0, speed_hi = 0, sync_sel = 0;
    logic orig_sel = 0, aloop_req = 0, lloop_req = 0, rloop_req = 0, rloop_ack = 0;
    logic term_txd = 0, rx_data = 0, int_tx_clk = 0, rx_rec_clk = 0;
    logic [1:0] op_mode;
    logic rx_band_orig, iso_out, term_rxd, tx_data_out, tx_clk_out, rl_status;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    modem_path_router i_modem_path_router (
        .clk(clk), .rst_n(rst_n), .test_sel(test_sel), .hs_phase1(hs_phase1),
        .hs_phase2(hs_phase2), .speed_hi(speed_hi), .sync_sel(sync_sel),
        .orig_sel(orig_sel), .aloop_req(aloop_req), .lloop_req(lloop_req),
        .rloop_req(rloop_req), .rloop_ack(rloop_ack), .term_txd(term_txd),
        .rx_data(rx_data), .int_tx_clk(int_tx_clk), .rx_rec_clk(rx_rec_clk),
        .op_mode(op_mode), .rx_band_orig(rx_band_orig), .iso_out(iso_out),
        .term_rxd(term_rxd), .tx_data_out(tx_data_out), .tx_clk_out(tx_clk_out),
        .rl_status(rl_status)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_pins(input logic [9:0] v);
        {test_sel, hs_phase1, hs_phase2, speed_hi, sync_sel,
         orig_sel, aloop_req, lloop_req, rloop_req, rloop_ack} = v;
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        // R8: reset state
        #12;
        check("R8 op_mode", op_mode, 0);
        check("R8 iso_out", iso_out, 0);
        check("R8 rx_band_orig", rx_band_orig, 0);
        check("R8 rl_status", rl_status, 0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_edges(4);

        // R7: latency, from dialer to high-speed synchronous
        set_pins(10'b1_0_0_1_1_0_0_0_0_0);
        wait_edges(2);
        check("R7 no change after two edges", op_mode, 0);
        wait_edges(1);
        check("R7 change on third edge", op_mode, 2);

        // Sweep over every pin pattern
        for (int v = 0; v < 1024; v++) begin
            logic [9:0] pv;
            logic dial, high, lloop_on, grant;
            int exp_mode;
            pv = v[9:0];
            set_pins(pv);
            wait_edges(4);
            dial     = !(pv[9] | pv[8] | pv[7]);
            high     = pv[6];
            lloop_on = !dial && pv[2];
            grant    = !dial && high && pv[1] && !pv[2];
            exp_mode = dial ? 0 : (!high ? 1 : (pv[5] ? 2 : 3));
            check(dial ? "R1 mode" : "R2 mode", op_mode, exp_mode);
            check(dial ? "R1 band" : "R3 band", rx_band_orig, pv[4] ^ (!dial && pv[3]));
            check(dial ? "R1 iso" : "R4 iso", iso_out, lloop_on);
            check(dial ? "R1 rl_status" : "R6 rl_status", rl_status, grant && pv[0]);
            for (int p = 0; p < 16; p++) begin
                logic [3:0] pp;
                pp = p[3:0];
                {rx_data, term_txd, int_tx_clk, rx_rec_clk} = pp;
                #0.5;
                check("R4 term_rxd", term_rxd, lloop_on ? 1 : pp[3]);
                check("R4 tx_data_out", tx_data_out, lloop_on ? pp[3] : pp[2]);
                check("R5 tx_clk_out", tx_clk_out, (lloop_on && high) ? pp[0] : pp[1]);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule